// File: doc/BRIEF.md
# Core and Timer Clock-Enable Prescaler

This block runs entirely on one fast base clock and turns it into enable strobes. The processor cores get one strobe and the timer, capture, wait and baud-rate logic get another. Each strobe comes from its own programmable divider. Either domain can therefore act on every base-clock edge while the other acts on only one edge in N. The base clock always keeps its full frequency. Downstream logic simply uses the strobe as a clock enable.

A fractional mode gives every core its own share of the base clocks, from 1/8 to 8/8. The enabled edges are spread evenly across a window of eight clocks, and that window is locked to a 3-bit hub-slot phase counter. The counter is also an output, so the hub's eight-way round-robin and every core's enable pattern share one phase. A core's wait for its hub slot is therefore the same on every turn.

Top module: `clk_ratio_strobes`

## Requirements
- R1: While `rst_n` is low, every bit of `core_en` and `tmr_en` is 1 and `hub_slot` is 0, whatever the other inputs are.
- R2: `hub_slot` advances by one on every base clock and wraps from 7 to 0.
- R3: A divider setting D from 2 to 16 gives one strobe every D base clocks. A setting of 0 or 1 gives a strobe on every clock. Settings above 16 act as 16.
- R4: The legacy preset (`core_div`=4, `tmr_div`=1) gives a core strobe every 4 clocks and a timer strobe on every clock.
- R5: The converse preset (`core_div`=0, `tmr_div`=N) gives a core strobe on every clock and a timer strobe every N clocks.
- R6: A new divider value is adopted only on that divider's strobe. The period already running ends at the old length, and later periods use the new length.
- R7: With `mode_frac`=0, every bit of `core_en` equals the core-divider strobe.
- R8: With `mode_frac`=1, core i reads its 3-bit code c from `core_frac[3i+2:3i]` and sets k=c+1. That core is enabled on exactly those slots s where ((s*k) mod 8)+k >= 8, which gives k enables per 8 slots. Code 7 enables the core on every clock, and code 0 enables it only in slot 7.
- R9: In fractional mode with fixed codes, the `core_en` pattern repeats exactly every 8 clocks.
- R10: The timer strobe does not depend on `mode_frac`, `core_frac` or `core_div`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| core_div | input | 5 | Core divider setting |
| tmr_div | input | 5 | Timer divider setting |
| mode_frac | input | 1 | 1 selects the per-core fractional enables |
| core_frac | input | 24 | Per-core 3-bit ratio codes, 3 bits for each core |
| core_en | output | 8 | Per-core clock-enable strobes |
| tmr_en | output | 1 | Timer, wait and baud clock-enable strobe |
| hub_slot | output | 3 | Hub rotation phase |

## Verification
The embedded properties are checked on every cycle. They cover the hub-slot step and wrap, that divider mode drives all cores alike, that a full-rate timer setting yields back-to-back strobes, that the timer gap never exceeds sixteen clocks, and the fixed endpoints of the fractional ratio (code 7 always on, code 0 only in slot 7). Only the directed scenarios can show the following: exact strobe spacing for each divider value, the clamp of out-of-range settings, the old period finishing when a divider changes in mid-count, the full slot pattern and its eight-clock repetition, and the timer staying independent of the core settings.

// File: rtl/clk_ratio_strobes.sv
module clk_ratio_strobes #(
  parameter int NUM_CORES = 8,
  parameter int DIV_W     = 5,
  parameter int DIV_MAX   = 16,
  parameter int SLOT_W    = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [DIV_W-1:0]            core_div,
  input  logic [DIV_W-1:0]            tmr_div,
  input  logic                        mode_frac,
  input  logic [NUM_CORES*SLOT_W-1:0] core_frac,
  output logic [NUM_CORES-1:0]        core_en,
  output logic                        tmr_en,
  output logic [SLOT_W-1:0]           hub_slot
);
  localparam int SLOTS = 1 << SLOT_W;
  localparam int CNT_W = $clog2(DIV_MAX);
  localparam int KW    = SLOT_W + 2;

  logic [DIV_W-1:0] div_in [2];
  logic [1:0]       tc;

  assign div_in[0] = core_div;
  assign div_in[1] = tmr_div;

  for (genvar g = 0; g < 2; g++) begin : g_div
    logic [CNT_W-1:0] cnt, last, nxt_last;

    always_comb begin
      if (div_in[g] > DIV_W'(DIV_MAX)) nxt_last = CNT_W'(DIV_MAX - 1);
      else if (div_in[g] == '0)        nxt_last = '0;
      else                             nxt_last = CNT_W'(div_in[g] - 1'b1);
    end

    assign tc[g] = (cnt == last);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt  <= '0;
        last <= '0;
      end else if (tc[g]) begin
        cnt  <= '0;
        last <= nxt_last;
      end else begin
        cnt  <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hub_slot <= '0;
    else        hub_slot <= hub_slot + 1'b1;
  end

  assign tmr_en = tc[1];

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
    logic [KW-1:0]        k;
    logic [2*KW-1:0]      prod;
    logic [KW-1:0]        acc;
    logic                 hit;

    assign k    = KW'(core_frac[i*SLOT_W +: SLOT_W]) + 1'b1;
    assign prod = (2*KW)'(hub_slot) * (2*KW)'(k);
    assign acc  = KW'(prod[SLOT_W-1:0]) + k;
    assign hit  = (acc >= KW'(SLOTS));
    assign core_en[i] = !rst_n | (mode_frac ? hit : tc[0]);

    p_frac_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_frac && core_frac[i*SLOT_W +: SLOT_W] == '1) |-> core_en[i]);
    p_frac_min_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_frac && core_frac[i*SLOT_W +: SLOT_W] == '0 && core_en[i])
        |-> hub_slot == SLOT_W'(SLOTS - 1));
  end

  logic [CNT_W:0] tmr_gap;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tmr_gap <= '0;
    else if (tmr_en) tmr_gap <= '0;
    else             tmr_gap <= tmr_gap + 1'b1;
  end

  p_slot_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> hub_slot == $past(hub_slot) + 1'b1);
  p_gap_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_gap < (CNT_W+1)'(DIV_MAX));
  p_full_rate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_en && tmr_div <= DIV_W'(1)) |=> tmr_en);
  p_cores_alike_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_frac |-> (core_en == {NUM_CORES{core_en[0]}}));
endmodule

// File: tb/clk_ratio_strobes_tb.sv
module clk_ratio_strobes_tb;
  localparam int NC = 8;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [4:0]    core_div = '0, tmr_div = '0;
  logic          mode_frac = 1'b0;
  logic [NC*3-1:0] core_frac = '0;
  logic [NC-1:0] core_en;
  logic          tmr_en;
  logic [2:0]    hub_slot;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  clk_ratio_strobes u_dut (.clk(clk), .rst_n(rst_n), .core_div(core_div),
    .tmr_div(tmr_div), .mode_frac(mode_frac), .core_frac(core_frac),
    .core_en(core_en), .tmr_en(tmr_en), .hub_slot(hub_slot));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit sig(input bit sel);
    return sel ? tmr_en : core_en[0];
  endfunction

  task automatic next_strobe(input bit sel, output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!sig(sel) && n < 100);
  endtask

  task automatic gaps(input string req, input bit sel, input int exp);
    int n;
    next_strobe(sel, n);
    for (int j = 0; j < 3; j++) begin
      next_strobe(sel, n);
      chk(req, n, exp);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; mode_frac = 1'b1; core_frac = '0; core_div = 5'd9; tmr_div = 5'd9;
    repeat (3) @(negedge clk);
    chk("R1 core_en", int'(core_en), 255);
    chk("R1 tmr_en", int'(tmr_en), 1);
    chk("R1 hub_slot", int'(hub_slot), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_slot;
    int exp_s;
    @(negedge clk);
    exp_s = int'(hub_slot);
    for (int j = 0; j < 20; j++) begin
      @(negedge clk);
      exp_s = (exp_s + 1) % 8;
      chk("R2 slot", int'(hub_slot), exp_s);
    end
  endtask

  task automatic t_sweep;
    int vals [7] = '{0, 1, 2, 3, 5, 16, 20};
    int effs [7] = '{1, 1, 2, 3, 5, 16, 16};
    mode_frac = 1'b0;
    for (int v = 0; v < 7; v++) begin
      tmr_div = 5'(vals[v]);
      gaps("R3 timer", 1'b1, effs[v]);
    end
    core_div = 5'd6;
    gaps("R3 core", 1'b0, 6);
  endtask

  task automatic t_legacy;
    int nc, nt;
    core_div = 5'd4; tmr_div = 5'd1; mode_frac = 1'b0;
    gaps("R4 core", 1'b0, 4);
    nc = 0; nt = 0;
    for (int j = 0; j < 8; j++) begin
      @(negedge clk);
      nc += int'(core_en[0]); nt += int'(tmr_en);
    end
    chk("R4 core count", nc, 2);
    chk("R4 timer count", nt, 8);
  endtask

  task automatic t_converse;
    core_div = 5'd0; tmr_div = 5'd7;
    gaps("R5 core", 1'b0, 1);
    gaps("R5 timer", 1'b1, 7);
  endtask

  task automatic t_change;
    int n;
    tmr_div = 5'd3;
    gaps("R6 setup", 1'b1, 3);
    @(negedge clk);
    tmr_div = 5'd7;
    next_strobe(1'b1, n);
    chk("R6 old period finishes", n, 2);
    next_strobe(1'b1, n);
    chk("R6 new period", n, 7);
    tmr_div = 5'd8;
    gaps("R6 setup", 1'b1, 8);
    repeat (2) @(negedge clk);
    tmr_div = 5'd2;
    next_strobe(1'b1, n);
    chk("R6 old period finishes", n, 6);
    next_strobe(1'b1, n);
    chk("R6 new period", n, 2);
  endtask

  task automatic t_cores_alike;
    int cnt;
    mode_frac = 1'b0; core_div = 5'd3;
    gaps("R7 setup", 1'b0, 3);
    cnt = 0;
    for (int j = 0; j < 12; j++) begin
      @(negedge clk);
      chk("R7 all alike", int'(core_en == {NC{core_en[0]}}), 1);
      cnt += int'(core_en[0]);
    end
    chk("R7 count", cnt, 4);
  endtask

  task automatic t_frac;
    logic [NC-1:0] pat [16];
    int cnt [NC];
    for (int i = 0; i < NC; i++) core_frac[i*3 +: 3] = 3'(i);
    mode_frac = 1'b1; core_div = 5'd5; tmr_div = 5'd5;
    do @(negedge clk); while (hub_slot != 3'd0);
    for (int i = 0; i < NC; i++) cnt[i] = 0;
    for (int j = 0; j < 16; j++) begin
      for (int i = 0; i < NC; i++) begin
        int k = i + 1;
        bit e = (((j % 8) * k) % 8 + k) >= 8;
        chk($sformatf("R8 core%0d slot%0d", i, j % 8), int'(core_en[i]), int'(e));
        if (j < 8) cnt[i] += int'(core_en[i]);
      end
      pat[j] = core_en;
      @(negedge clk);
    end
    for (int i = 0; i < NC; i++) chk("R8 count per window", cnt[i], i + 1);
    for (int j = 0; j < 8; j++) chk("R9 repeat", int'(pat[j]), int'(pat[j + 8]));
  endtask

  task automatic t_indep;
    gaps("R10 timer in frac mode", 1'b1, 5);
    core_frac = '1; core_div = 5'd11;
    gaps("R10 timer after core change", 1'b1, 5);
    mode_frac = 1'b0;
    gaps("R10 timer after mode change", 1'b1, 5);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset;
    t_slot;
    t_sweep;
    t_legacy;
    t_converse;
    t_change;
    t_cores_alike;
    t_frac;
    t_indep;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule